// File: doc/BRIEF.md
# SPI Serial EEPROM Command Sequencer

This block is the master side of a link to a serial EEPROM on an SPI bus. A client hands it one request at a time: read the status byte, set the write latch, write one data byte, or read one data byte. The block expands each request into complete chip-select frames. It sends the opcode, the two address bytes, the data byte or a dummy byte, and captures the byte that comes back. A write request is handled in full by the block. It first polls the status byte until the device reports that it is idle. It then sets the device's write latch in a frame of its own, and only after that sends the write frame.

All frames use SPI mode 0, most significant bit first. A single byte-wide shift engine sends and receives at the same time. The serial clock comes from the system clock through a divider whose half period is `SCLK_HALF` system cycles.

The request side uses valid/ready. A request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low until the whole sequence and the closing chip-select gap have finished, so the client holds or retries its request. Completion is not back-pressured. `done` is a single-cycle pulse, and `rd_data` holds its value until the next pulse.

Top module: `spi_ee_seq`

## Requirements
- R1: While reset is asserted and right after it: `ee_cs_n`=1, `ee_sclk`=0, `req_ready`=1, `done`=0.
- R2: SPI mode 0. `ee_sclk` is low whenever `ee_cs_n` is high. `ee_mosi` holds steady while `ee_sclk` is high. The slave samples on the rising edge and so does the block (on `ee_miso`). Each byte goes out MSB first.
- R3: Within a byte, consecutive rising edges of `ee_sclk` are exactly 2×`SCLK_HALF` system cycles apart.
- R4: `req_cmd` encodes the request: 0 = status, 1 = write enable, 2 = write, 3 = read. A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` is low whenever chip select is active. A request presented while `req_ready` is low has no effect.
- R5: A status request makes one frame: 0x05, then 0x00. `rd_data` is set to the byte returned during the second byte.
- R6: A write-enable request makes one single-byte frame: 0x06.
- R7: A read request makes one frame: 0x03, address[15:8], address[7:0], 0x00. `rd_data` is set to the byte returned during the fourth byte.
- R8: A write request makes status frames (0x05, 0x00) for as long as bit 0 of the returned status is 1. It then makes one more status frame, which returns bit 0 = 0. Then comes a 0x06 frame, and then a frame of 0x02, address[15:8], address[7:0], data.
- R9: Between two frames `ee_cs_n` stays high for at least 2×`SCLK_HALF` system cycles.
- R10: `done` is high for exactly one cycle, in the cycle where `ee_cs_n` rises at the end of a request's last frame. `rd_data` changes only in a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, can take a request |
| req_cmd | input | 2 | Request kind (R4 encoding) |
| req_addr | input | 16 | EEPROM byte address |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Status or read byte of the last request |
| ee_cs_n | output | 1 | Chip select, active low |
| ee_sclk | output | 1 | Serial clock |
| ee_mosi | output | 1 | Serial data to the device |
| ee_miso | input | 1 | Serial data from the device |

## Verification
A wrong frame state or byte index shows up in the bench's EEPROM model within one frame. The frame then carries an opcode or address byte that does not match the expected sequence, or the wrong number of bytes between the chip-select edges. A wrong decision on the status bit shows as a missing or extra poll frame, or as a write frame reaching the model while its write latch is clear. A divider or shift-counter fault breaks the bit period within a single byte, and garbles the byte returned by the next read.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  typedef enum logic [1:0] {
    REQ_STATUS = 2'd0,
    REQ_WREN   = 2'd1,
    REQ_WRITE  = 2'd2,
    REQ_READ   = 2'd3
  } req_e;

  typedef enum logic [1:0] {
    FR_RDSR,
    FR_WREN,
    FR_WRITE,
    FR_READ
  } frame_e;

  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  function automatic logic [1:0] frame_last(frame_e f);
    case (f)
      FR_RDSR: return 2'd1;
      FR_WREN: return 2'd0;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/spi_ee_tick.sv
module spi_ee_tick #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_ee_shift.sv
module spi_ee_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] tx_byte,
  input  logic         tick,
  input  logic         miso,
  output logic         active,
  output logic         done,
  output logic [W-1:0] rx_byte,
  output logic         sclk,
  output logic         mosi
);
  localparam int CW = $clog2(W);
  logic [W-1:0]  txs, rxs;
  logic [CW-1:0] bitn;

  assign rx_byte = rxs;
  assign mosi    = txs[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txs <= '0; rxs <= '0; bitn <= '0;
      sclk <= 1'b0; active <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        txs    <= tx_byte;
        bitn   <= '0;
        sclk   <= 1'b0;
      end else if (active && tick) begin
        if (!sclk) begin
          sclk <= 1'b1;
          rxs  <= {rxs[W-2:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == CW'(W - 1)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitn <= bitn + 1'b1;
            txs  <= {txs[W-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_ee_fsm.sv
module spi_ee_fsm
  import spi_ee_pkg::*;
#(
  parameter int HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_cmd,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  input  logic        sh_done,
  input  logic [7:0]  sh_rx,
  output logic        sh_start,
  output logic [7:0]  sh_tx,
  output logic        cs_n,
  output logic        done,
  output logic [7:0]  rd_data
);
  localparam int GAP = 2 * HALF;
  localparam int GW  = $clog2(GAP + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_GAP} st_e;
  st_e           st;
  frame_e        frame, nxt_frame;
  logic          nxt_valid;
  req_e          op;
  logic [1:0]    idx;
  logic [15:0]   addr;
  logic [7:0]    wdata;
  logic [GW-1:0] gap_cnt;

  function automatic logic [7:0] byte_at(frame_e f, logic [1:0] i,
                                         logic [15:0] a, logic [7:0] d);
    case (f)
      FR_RDSR: return (i == 2'd0) ? OP_RDSR : 8'h00;
      FR_WREN: return OP_WREN;
      FR_WRITE:
        case (i)
          2'd0:    return OP_WRITE;
          2'd1:    return a[15:8];
          2'd2:    return a[7:0];
          default: return d;
        endcase
      default:
        case (i)
          2'd0:    return OP_READ;
          2'd1:    return a[15:8];
          2'd2:    return a[7:0];
          default: return 8'h00;
        endcase
    endcase
  endfunction

  function automatic frame_e first_frame(req_e r);
    case (r)
      REQ_WREN: return FR_WREN;
      REQ_READ: return FR_READ;
      default:  return FR_RDSR;
    endcase
  endfunction

  assign req_ready = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; frame <= FR_RDSR; nxt_frame <= FR_RDSR; nxt_valid <= 1'b0;
      op <= REQ_STATUS; idx <= '0; addr <= '0; wdata <= '0; gap_cnt <= '0;
      sh_start <= 1'b0; sh_tx <= '0; cs_n <= 1'b1; done <= 1'b0; rd_data <= '0;
    end else begin
      sh_start <= 1'b0;
      done     <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          op       <= req_e'(req_cmd);
          addr     <= req_addr;
          wdata    <= req_wdata;
          frame    <= first_frame(req_e'(req_cmd));
          idx      <= '0;
          cs_n     <= 1'b0;
          sh_start <= 1'b1;
          sh_tx    <= byte_at(first_frame(req_e'(req_cmd)), 2'd0, req_addr, req_wdata);
          st       <= ST_XFER;
        end
        ST_XFER: if (sh_done) begin
          if (idx == frame_last(frame)) begin
            cs_n    <= 1'b1;
            gap_cnt <= '0;
            st      <= ST_GAP;
            case (frame)
              FR_RDSR:
                if (op == REQ_WRITE) begin
                  nxt_valid <= 1'b1;
                  nxt_frame <= sh_rx[0] ? FR_RDSR : FR_WREN;
                end else begin
                  done    <= 1'b1;
                  rd_data <= sh_rx;
                end
              FR_WREN:
                if (op == REQ_WRITE) begin
                  nxt_valid <= 1'b1;
                  nxt_frame <= FR_WRITE;
                end else begin
                  done <= 1'b1;
                end
              FR_WRITE: done <= 1'b1;
              default: begin
                done    <= 1'b1;
                rd_data <= sh_rx;
              end
            endcase
          end else begin
            idx      <= idx + 1'b1;
            sh_start <= 1'b1;
            sh_tx    <= byte_at(frame, idx + 1'b1, addr, wdata);
          end
        end
        default: begin
          if (gap_cnt == GW'(GAP - 1)) begin
            if (nxt_valid) begin
              nxt_valid <= 1'b0;
              frame     <= nxt_frame;
              idx       <= '0;
              cs_n      <= 1'b0;
              sh_start  <= 1'b1;
              sh_tx     <= byte_at(nxt_frame, 2'd0, addr, wdata);
              st        <= ST_XFER;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_ee_seq.sv
module spi_ee_seq #(
  parameter int SCLK_HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_cmd,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        done,
  output logic [7:0]  rd_data,
  output logic        ee_cs_n,
  output logic        ee_sclk,
  output logic        ee_mosi,
  input  logic        ee_miso
);
  logic       sh_start, sh_done, sh_active, tick;
  logic [7:0] sh_tx, sh_rx;

  spi_ee_tick #(.HALF(SCLK_HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(sh_active), .tick(tick)
  );

  spi_ee_shift #(.W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_tx), .tick(tick),
    .miso(ee_miso), .active(sh_active), .done(sh_done), .rx_byte(sh_rx),
    .sclk(ee_sclk), .mosi(ee_mosi)
  );

  spi_ee_fsm #(.HALF(SCLK_HALF)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata),
    .sh_done(sh_done), .sh_rx(sh_rx), .sh_start(sh_start), .sh_tx(sh_tx),
    .cs_n(ee_cs_n), .done(done), .rd_data(rd_data)
  );
endmodule

// File: rtl/spi_ee_seq_chk.sv
module spi_ee_seq_chk #(
  parameter int SCLK_HALF = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       done,
  input logic [7:0] rd_data,
  input logic       ee_cs_n,
  input logic       ee_sclk,
  input logic       ee_mosi
);
  localparam int GAP = 2 * SCLK_HALF;
  logic [15:0] hi_cnt;
  logic        armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      armed  <= 1'b0;
    end else begin
      if (!ee_cs_n)                 armed  <= 1'b1;
      if (!ee_cs_n)                 hi_cnt <= '0;
      else if (hi_cnt != 16'hFFFF)  hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_CLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ee_cs_n |-> !ee_sclk); // R2
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!ee_cs_n && ee_sclk && $past(ee_sclk)) |-> $stable(ee_mosi)); // R2
  AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs_n |-> !req_ready); // R4
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(ee_cs_n)) |-> (hi_cnt >= 16'(GAP))); // R9
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(ee_cs_n)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data != $past(rd_data)) |-> done); // R10
endmodule

bind spi_ee_seq spi_ee_seq_chk #(.SCLK_HALF(SCLK_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .rd_data(rd_data), .ee_cs_n(ee_cs_n), .ee_sclk(ee_sclk), .ee_mosi(ee_mosi)
);

// File: tb/sim_spi_ee_seq.sv
`timescale 1ns/1ps
module sim_spi_ee_seq;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready, done, ee_cs_n, ee_sclk, ee_mosi;
  logic ee_miso = 1'b0;
  logic [1:0]  req_cmd = '0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, rd_data;

  always #2 clk = ~clk;

  spi_ee_seq #(.SCLK_HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .ee_cs_n(ee_cs_n), .ee_sclk(ee_sclk),
    .ee_mosi(ee_mosi), .ee_miso(ee_miso)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  // ---------------- EEPROM behavioural slave ----------------
  logic [7:0] mem  [256];
  logic [7:0] gold [256];
  logic [7:0] fb   [8];
  logic [7:0] flog [16];
  logic [7:0] shin, osr;
  int  bitc, bytec, nf = 0, wip_left = 0, prot_err = 0, frag_err = 0, per_err = 0, per_cnt = 0;
  bit  wel = 0, open_f = 0;
  logic [15:0] last_wr_addr = '0, last_rd_addr = '0;
  realtime last_rise = 0;

  always @(negedge ee_cs_n) begin
    bitc = 0; bytec = 0; open_f = 1; osr = 8'h00; ee_miso = 1'b0;
  end

  always @(posedge ee_sclk) if (!ee_cs_n) begin
    if (bitc != 0) begin
      per_cnt++;
      if ($realtime - last_rise != 2.0 * HALF * 4.0) per_err++;
    end
    last_rise = $realtime;
    shin = {shin[6:0], ee_mosi};
    bitc++;
    if (bitc == 8) begin
      if (bytec < 8) fb[bytec] = shin;
      bytec++;
      bitc = 0;
    end
  end

  always @(negedge ee_sclk) if (!ee_cs_n) begin
    if (bitc == 0) begin
      osr = 8'h00;
      if (fb[0] == 8'h05 && bytec == 1) begin
        osr = {6'b0, wel, (wip_left != 0)};
        if (wip_left != 0) wip_left--;
      end else if (fb[0] == 8'h03 && bytec == 3) begin
        osr = mem[fb[2]];
      end
    end else begin
      osr = {osr[6:0], 1'b0};
    end
    ee_miso = osr[7];
  end

  always @(posedge ee_cs_n) if (open_f) begin
    open_f = 0;
    if (bitc != 0) frag_err++;
    if (nf < 16) flog[nf] = fb[0];
    nf++;
    if (fb[0] == 8'h06 && bytec == 1) wel = 1;
    if (fb[0] == 8'h02 && bytec == 4) begin
      if (!wel) prot_err++;
      else begin
        mem[fb[2]] = fb[3];
        last_wr_addr = {fb[1], fb[2]};
      end
      wel = 0;
    end
    if (fb[0] == 8'h03 && bytec == 4) last_rd_addr = {fb[1], fb[2]};
  end

  // chip-select gap monitor (R9)
  int hi_run = 0, min_gap = 1 << 30;
  bit seen_low = 0;
  always @(posedge clk) begin
    if (ee_cs_n) hi_run++;
    else begin
      if (seen_low && hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
      if (hi_run > 0) seen_low = 1;
      hi_run = 0;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected < 190000", cyc);
      summary();
    end
  end

  logic [7:0] got;
  bit exp_wel = 0;

  // Issue one request; returns when done has pulsed and the block is idle again.
  task automatic do_req(logic [1:0] c, logic [15:0] a, logic [7:0] d, bit poke_busy);
    int t;
    nf = 0;
    @(negedge clk);
    req_valid = 1; req_cmd = c; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    t = 0;
    repeat (3) @(negedge clk);
    if (poke_busy) begin
      chk(req_ready == 0, "R4", "ready while busy", req_ready, 0);
      req_valid = 1; req_cmd = 2'd1;
      repeat (3) @(negedge clk);
      req_valid = 0;
    end
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(t < 20000, "R10", "done seen", t, 0);
    got = rd_data;
    chk(ee_cs_n == 1, "R10", "cs released at done", ee_cs_n, 1);
    @(negedge clk);
    chk(done == 0, "R10", "done one cycle", done, 0);
    chk(rd_data == got, "R10", "rd_data held", rd_data, got);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic req_status();
    logic [7:0] e;
    e = {6'b0, exp_wel, 1'b0};
    do_req(2'd0, 16'h0, 8'h0, 0);
    chk(nf == 1 && flog[0] == 8'h05, "R5", "status frame", flog[0], 8'h05);
    chk(got == e, "R5", "status byte", got, e);
  endtask

  task automatic req_wren();
    do_req(2'd1, 16'h0, 8'h0, 0);
    chk(nf == 1 && flog[0] == 8'h06, "R6", "wren frame", flog[0], 8'h06);
    exp_wel = 1;
  endtask

  task automatic req_write(logic [15:0] a, logic [7:0] d, int w);
    bit ok;
    wip_left = w;
    do_req(2'd2, a, d, 0);
    ok = (nf == w + 3);
    for (int i = 0; i <= w && i < 16; i++) ok &= (flog[i] == 8'h05);
    if (w + 2 < 16) ok &= (flog[w+1] == 8'h06) && (flog[w+2] == 8'h02);
    chk(ok, "R8", "poll/enable/write frame order (frames)", nf, w + 3);
    chk(last_wr_addr == a, "R8", "write address", last_wr_addr, a);
    chk(mem[a[7:0]] == d, "R8", "stored byte", mem[a[7:0]], d);
    chk(prot_err == 0, "R8", "write without enable", prot_err, 0);
    gold[a[7:0]] = d;
    exp_wel = 0;
  endtask

  task automatic req_read(logic [15:0] a, bit poke);
    do_req(2'd3, a, 8'h0, poke);
    chk(nf == 1 && flog[0] == 8'h03, "R7", "read frame", flog[0], 8'h03);
    chk(last_rd_addr == a, "R7", "read address", last_rd_addr, a);
    chk(got == gold[a[7:0]], "R7", "read data", got, gold[a[7:0]]);
    if (poke) chk(nf == 1, "R4", "request while busy ignored (frames)", nf, 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'($urandom);
      gold[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ee_cs_n == 1 && ee_sclk == 0, "R1", "bus idle in reset", {ee_cs_n, ee_sclk}, 2'b10);
    chk(req_ready == 1 && done == 0, "R1", "ready/done in reset", {req_ready, done}, 2'b10);
    rst_n = 1;
    @(negedge clk);
    chk(ee_cs_n == 1 && req_ready == 1, "R1", "state after reset", {ee_cs_n, req_ready}, 2'b11);

    // directed corners
    req_status();
    req_wren();
    req_status();                          // write latch visible
    req_write(16'h12A5, 8'h3C, 2);         // two busy polls
    req_status();                          // latch cleared by write
    req_read(16'h12A5, 0);
    req_write(16'hFF00, 8'hFF, 0);         // device already idle
    req_read(16'hFF00, 1);                 // extra request while busy (R4)
    req_read(16'h0000, 0);

    // random mix
    for (int n = 0; n < 40; n++) begin
      int k;
      logic [15:0] a;
      k = int'($urandom % 4);
      a = 16'($urandom);
      case (k)
        0: req_status();
        1: req_wren();
        2: req_write(a, 8'($urandom), int'($urandom % 4));
        default: req_read(a, 0);
      endcase
    end

    chk(per_cnt > 0 && per_err == 0, "R3", "bit period errors", per_err, 0);
    chk(frag_err == 0, "R2", "partial bytes in frames", frag_err, 0);
    chk(min_gap >= 2 * HALF, "R9", "min chip-select gap", min_gap, 2 * HALF);
    summary();
  end
endmodule